// File: doc/BRIEF.md
# Reference Clock Source Selector

This block decides which of several candidate reference inputs a digital PLL should try to lock to. It does not move any clock. It looks at per-input quality flags, per-input priority fields, a mode bit, a forced-select field and an external fast-switch pin. From these it produces a registered index of the chosen input and a flag that says whether that index is meaningful. A separate clock multiplexer uses the index, and separate monitors supply the quality flags.

There are three modes, checked in a fixed order. When the external-switch mode bit is set, the pin alone picks between two designated fast inputs. When the mode bit is clear and the forced field is nonzero, the field names the input directly. When the mode bit is clear and the forced field is zero, the block chooses automatically: it takes the best-priority input among those that are healthy. A priority of zero always means the input is disabled.

The mode bit is loaded from the synchronized pin level for as long as reset is held. After reset, software can change it through a one-cycle write strobe.

Top module: `refclk_selector`

## Requirements
- R1: While `rst_n` is low, `sel_valid` is 0 and `sel_idx` is 0 from the first clock edge after reset is asserted.
- R2: While reset is held for at least three clocks, the mode bit takes the level of `fast_pin`. A high level starts the block in fast mode, and a low level starts it with the mode bit clear.
- R3: When the mode bit is 1, `force_sel` and `qual_ok` have no effect on the outputs.
- R4: In fast mode with `fast_pin` high and a nonzero priority on input FAST_A, the output is FAST_A and valid. With `fast_pin` low and a nonzero priority on input FAST_B, the output is FAST_B and valid.
- R5: In fast mode, when the input the pin points at has priority 0, `sel_valid` is 0.
- R6: When the mode bit is 0 and `force_sel` = k with 1 ≤ k ≤ N_IN, the output is input k-1 and valid. Quality and priority are ignored.
- R7: When the mode bit is 0 and `force_sel` > N_IN, `sel_valid` is 0.
- R8: When the mode bit is 0 and `force_sel` = 0, the output is the input whose `qual_ok` bit is 1 and whose priority is nonzero and numerically smallest. Equal priorities go to the lower index. If no input qualifies, `sel_valid` is 0.
- R9: Whenever `sel_valid` is 0, `sel_idx` is 0.
- R10: A change on `force_sel`, `qual_ok` or `prio` shows at the outputs after exactly one rising edge. A change on `fast_pin` shows after exactly three rising edges (two synchronizer stages plus the output register).
- R11: A write with `cfg_we`=1 sets the mode bit to `cfg_ext_sw` at that edge. The new mode shows at the outputs one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fast_pin | input | 1 | Asynchronous fast-switch pin (high = FAST_A) |
| cfg_we | input | 1 | Mode bit write strobe |
| cfg_ext_sw | input | 1 | Mode bit write value |
| force_sel | input | SEL_W | Forced-select field; 0 = automatic, k = input k-1 |
| qual_ok | input | N_IN | Per-input quality-valid flags |
| prio | input | N_IN*PRIO_W | Per-input priority, input i at bits [i*PRIO_W +: PRIO_W]; 0 = disabled |
| sel_idx | output | IDX_W | Selected input index |
| sel_valid | output | 1 | Selection is meaningful |

## Verification
The bench builds the selector with four inputs, 2-bit priorities and a 3-bit forced field, and places the fast inputs at indices 2 and 3. With this shape, automatic mode can be swept over all 4096 combinations of quality flags and priority words, so every tie and every empty set is covered. The 3-bit forced field reaches both the in-range values and the out-of-range values 5 to 7. Putting the fast inputs away from index 0 keeps a fast-mode result apart from a reset value or a forced value.

// File: rtl/refclk_selector.sv
module refclk_selector #(
  parameter int N_IN   = 8,
  parameter int PRIO_W = 4,
  parameter int SEL_W  = 4,
  parameter int FAST_A = 0,
  parameter int FAST_B = 1,
  localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fast_pin,
  input  logic                     cfg_we,
  input  logic                     cfg_ext_sw,
  input  logic [SEL_W-1:0]         force_sel,
  input  logic [N_IN-1:0]          qual_ok,
  input  logic [N_IN*PRIO_W-1:0]   prio,
  output logic [IDX_W-1:0]         sel_idx,
  output logic                     sel_valid
);

  logic [1:0]        pin_sync;
  logic              pin_s;
  logic              mode_q;
  logic [PRIO_W-1:0] prio_a, prio_b;
  logic              fast_v;
  logic [IDX_W-1:0]  fast_i;
  logic              force_v;
  logic [IDX_W-1:0]  force_i;
  logic              auto_v;
  logic [IDX_W-1:0]  auto_i;
  logic              nxt_v;
  logic [IDX_W-1:0]  nxt_i;

  always_ff @(posedge clk) pin_sync <= {pin_sync[0], fast_pin};
  assign pin_s = pin_sync[1];

  assign prio_a = prio[FAST_A*PRIO_W +: PRIO_W];
  assign prio_b = prio[FAST_B*PRIO_W +: PRIO_W];
  assign fast_v = pin_s ? (prio_a != '0) : (prio_b != '0);
  assign fast_i = pin_s ? IDX_W'(FAST_A) : IDX_W'(FAST_B);

  assign force_v = (force_sel != '0) && (int'(force_sel) <= N_IN);
  assign force_i = IDX_W'(int'(force_sel) - 1);

  always_comb begin
    logic [PRIO_W-1:0] best;
    logic [PRIO_W-1:0] p;
    auto_v = 1'b0;
    auto_i = '0;
    best   = '0;
    for (int i = 0; i < N_IN; i++) begin
      p = prio[i*PRIO_W +: PRIO_W];
      if (qual_ok[i] && (p != '0) && (!auto_v || (p < best))) begin
        auto_v = 1'b1;
        best   = p;
        auto_i = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (mode_q) begin
      nxt_v = fast_v;
      nxt_i = fast_i;
    end else if (force_sel != '0) begin
      nxt_v = force_v;
      nxt_i = force_i;
    end else begin
      nxt_v = auto_v;
      nxt_i = auto_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= pin_s;
      sel_valid <= 1'b0;
      sel_idx   <= '0;
    end else begin
      if (cfg_we) mode_q <= cfg_ext_sw;
      sel_valid <= nxt_v;
      sel_idx   <= nxt_v ? nxt_i : '0;
    end
  end

endmodule

module refclk_selector_chk #(
  parameter int N_IN   = 8,
  parameter int PRIO_W = 4,
  parameter int SEL_W  = 4,
  parameter int FAST_A = 0,
  parameter int FAST_B = 1,
  parameter int IDX_W  = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   mode_q,
  input logic [SEL_W-1:0]       force_sel,
  input logic [N_IN-1:0]        qual_ok,
  input logic [N_IN*PRIO_W-1:0] prio,
  input logic [IDX_W-1:0]       sel_idx,
  input logic                   sel_valid
);

  function automatic logic bit_at(logic [N_IN-1:0] v, logic [IDX_W-1:0] k);
    return v[k];
  endfunction

  function automatic logic [PRIO_W-1:0] prio_at(logic [N_IN*PRIO_W-1:0] v, logic [IDX_W-1:0] k);
    return v[int'(k)*PRIO_W +: PRIO_W];
  endfunction

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !sel_valid); // R1

  AST_FAST_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) && sel_valid) |-> (sel_idx == IDX_W'(FAST_A) || sel_idx == IDX_W'(FAST_B))); // R4

  AST_FORCE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!mode_q && (int'(force_sel) > N_IN)) |-> !sel_valid); // R7

  AST_AUTO_HEALTHY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!mode_q && force_sel == '0) && sel_valid) |->
      (bit_at($past(qual_ok), sel_idx) && prio_at($past(prio), sel_idx) != '0)); // R8

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> (sel_idx == '0)); // R9

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (int'(sel_idx) < N_IN)); // R6

endmodule

bind refclk_selector refclk_selector_chk #(
  .N_IN(N_IN), .PRIO_W(PRIO_W), .SEL_W(SEL_W),
  .FAST_A(FAST_A), .FAST_B(FAST_B), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .force_sel(force_sel),
  .qual_ok(qual_ok), .prio(prio), .sel_idx(sel_idx), .sel_valid(sel_valid)
);

// File: tb/refclk_selector_bench.sv
module refclk_selector_bench;
  localparam int N  = 4;
  localparam int PW = 2;
  localparam int SW = 3;
  localparam int FA = 2;
  localparam int FB = 3;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       fast_pin = 0;
  logic       cfg_we = 0;
  logic       cfg_ext_sw = 0;
  logic [SW-1:0] force_sel = 0;
  logic [N-1:0]  qual_ok = 0;
  logic [N*PW-1:0] prio = 0;
  logic [1:0] sel_idx;
  logic       sel_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  refclk_selector #(.N_IN(N), .PRIO_W(PW), .SEL_W(SW), .FAST_A(FA), .FAST_B(FB)) u_refclk_selector (
    .clk(clk), .rst_n(rst_n), .fast_pin(fast_pin), .cfg_we(cfg_we), .cfg_ext_sw(cfg_ext_sw),
    .force_sel(force_sel), .qual_ok(qual_ok), .prio(prio),
    .sel_idx(sel_idx), .sel_valid(sel_valid)
  );

  always #10 clk = ~clk;

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic ev, int ei);
    n_chk++;
    if (sel_valid !== ev || int'(sel_idx) != ei) begin
      n_bad++;
      $display("FAIL %s: got valid=%0b idx=%0d, expected valid=%0b idx=%0d",
               req, sel_valid, sel_idx, ev, ei);
    end
  endtask

  function automatic int pr(logic [N*PW-1:0] p, int i);
    return int'(p[i*PW +: PW]);
  endfunction

  function automatic int auto_ref(logic [N-1:0] q, logic [N*PW-1:0] p);
    int best = 0;
    int idx = -1;
    for (int i = 0; i < N; i++)
      if (q[i] && pr(p, i) != 0 && (idx < 0 || pr(p, i) < best)) begin
        best = pr(p, i);
        idx = i;
      end
    return idx;
  endfunction

  initial begin
    #3_000_000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    // R1 and R2: reset with pin high gives fast mode
    fast_pin = 1; force_sel = 1; qual_ok = 0; prio = 8'b00_01_00_00;
    rst_n = 0;
    step(5);
    check("R1", 0, 0);
    rst_n = 1;
    step(1);
    check("R2 pin-high default -> fast, FAST_A", 1, FA);

    // R2: reset with pin low, mode bit clear, forced field selects input 0
    rst_n = 0; fast_pin = 0; prio = 8'b01_00_00_00;
    step(5);
    check("R1", 0, 0);
    rst_n = 1;
    step(1);
    check("R2 pin-low default -> forced input 0", 1, 0);

    // enter fast mode by a write
    cfg_we = 1; cfg_ext_sw = 1;
    step(1);
    cfg_we = 0;
    step(1);
    check("R11 write to fast mode", 1, FB);

    // R3 R4 R5 fast sweep
    for (int pin = 0; pin < 2; pin++)
      for (int pa = 0; pa < 4; pa++)
        for (int pb = 0; pb < 4; pb++)
          for (int qs = 0; qs < 4; qs++) begin
            logic ev;
            fast_pin = pin[0];
            prio = '0;
            prio[FA*PW +: PW] = pa[PW-1:0];
            prio[FB*PW +: PW] = pb[PW-1:0];
            prio[0 +: PW] = 2'(qs);
            qual_ok = 4'(qs * 5);
            force_sel = 3'(pa + pb + qs);
            step(3);
            ev = pin[0] ? (pa != 0) : (pb != 0);
            check(pin[0] ? (pa != 0 ? "R4 pin high" : "R5 A disabled")
                         : (pb != 0 ? "R4 pin low R3" : "R5 B disabled"),
                  ev, ev ? (pin[0] ? FA : FB) : 0);
          end

    // R10 pin latency: three edges
    prio = 8'b01_01_00_00; fast_pin = 0;
    step(3);
    check("R10 pin settle", 1, FB);
    fast_pin = 1;
    step(2);
    check("R10 pin after two edges still old", 1, FB);
    step(1);
    check("R10 pin after three edges", 1, FA);

    // R11 write latency back to register modes
    force_sel = 2; cfg_we = 1; cfg_ext_sw = 0;
    step(1);
    cfg_we = 0;
    check("R11 output unchanged at write edge", 1, FA);
    step(1);
    check("R11 new mode one edge later", 1, 1);

    // R6 R7 forced sweep
    for (int f = 0; f < 8; f++)
      for (int qs = 0; qs < 2; qs++) begin
        force_sel = 3'(f);
        qual_ok = qs ? 4'hF : 4'h0;
        prio = qs ? 8'hFF : 8'h00;
        if (f == 0) continue;
        step(1);
        if (f <= N) check("R6 forced", 1, f - 1);
        else        check("R7 out of range R9", 0, 0);
      end

    // R8 R9 exhaustive automatic sweep
    force_sel = 0;
    for (int q = 0; q < 16; q++)
      for (int p = 0; p < 256; p++) begin
        int e;
        qual_ok = 4'(q);
        prio = 8'(p);
        step(1);
        e = auto_ref(qual_ok, prio);
        check(e < 0 ? "R8 none qualifies R9" : "R8 auto", e >= 0, e < 0 ? 0 : e);
      end

    // R10 one-edge latency on data inputs
    qual_ok = 4'b0010; prio = 8'b00_00_01_00;
    step(1);
    check("R10 settle", 1, 1);
    qual_ok = 4'b0011; prio = 8'b00_00_01_01;
    #1;
    check("R10 not yet", 1, 1);
    step(1);
    check("R10 one edge", 1, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule